// File: doc/BRIEF.md
# Asynchronous External Memory Access Sequencer

This block shapes the control strobes for one asynchronous read or write to an external static memory, a pseudo-static RAM or a parallel NOR Flash. A request carries an address, write data, a direction flag and a flag that selects a shared address/data bus. Four programmable durations come with it. While the request is latched, the block steps through address setup, address hold (shared bus only), data setup and bus turnaround. Each phase is counted in system clock cycles.

The active-low chip select, output enable, write enable and address-valid strobes are decoded from the current phase. On a shared bus the data pins first carry the address, then carry write data or are released for the memory to drive. Read data is captured at the end of data setup, and a one-cycle done pulse marks that moment. A busy flag stays high until the turnaround gap has elapsed. Only then can a new request be taken.

Top module: `ext_mem_seq`

## Requirements
- R1: A request (`req_valid` high) is accepted on a clock edge only when the block is idle (`busy` low). `busy` is high from the cycle after acceptance until the last turnaround cycle. A request raised while `busy` is high is ignored and starts no access.
- R2: Phases run in the order address setup, address hold, data setup, turnaround, then idle. A setup or turnaround field of zero removes that phase and costs no cycle.
- R3: Address setup lasts `cfg_aset` cycles (0..15). Address hold lasts `cfg_ahld` cycles (1..15), with a field of 0 treated as 1, and occurs only when `req_muxed` is 1. Data setup lasts `cfg_dset`+1 cycles (1..256). Turnaround lasts `cfg_turn` cycles (0..15).
- R4: `mem_cs_n` is low through address setup, address hold and data setup, and high in turnaround and idle.
- R5: `mem_oe_n` is low only during data setup of a read (`req_write`=0). `mem_we_n` is low only during data setup of a write (`req_write`=1). The two are never low together.
- R6: `mem_adv_n` is low only during address setup.
- R7: `mem_ad_oe` is 1 and `mem_ad_out` equals the low address bits during address setup and hold of a shared-bus access. `mem_ad_oe` is 1 and `mem_ad_out` equals the write data during data setup of a write. `mem_ad_oe` is 0 at all other times. `mem_addr` holds the accepted address from acceptance until the next acceptance.
- R8: `rdata` takes the value of `mem_ad_in` from the last data setup cycle of a read. `done` is high for exactly the one cycle after the last data setup cycle.
- R9: While `rst_n` is low, and just after it rises, `busy` and `done` are 0, all four strobes are 1 and `mem_ad_oe` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request present |
| req_write | input | 1 | 1 = write, 0 = read |
| req_muxed | input | 1 | 1 = address and data share the data pins |
| req_addr | input | AW | Access address |
| req_wdata | input | DW | Write data |
| cfg_aset | input | 4 | Address setup cycles |
| cfg_ahld | input | 4 | Address hold cycles (0 read as 1) |
| cfg_dset | input | 8 | Data setup cycles minus one |
| cfg_turn | input | 4 | Turnaround cycles |
| busy | output | 1 | Access in progress |
| done | output | 1 | One-cycle completion pulse |
| rdata | output | DW | Captured read data |
| mem_addr | output | AW | Address pins |
| mem_ad_out | output | DW | Data pin output value |
| mem_ad_oe | output | 1 | Data pin output enable |
| mem_ad_in | input | DW | Data pin input value |
| mem_cs_n | output | 1 | Chip select, active low |
| mem_oe_n | output | 1 | Output enable, active low |
| mem_we_n | output | 1 | Write enable, active low |
| mem_adv_n | output | 1 | Address valid, active low |

## Verification
When the turnaround field is zero, the done pulse of one access and the acceptance of the next request fall in the same cycle. The bench sets this up by holding `req_valid` high across the end of a read. In the sampled cycle it expects `done` high with `busy` low. One cycle later it expects `busy`, chip select and address-valid asserted with the new address on the pins. A second overlap comes from pulsing a request during data setup. The bench then confirms that no further access starts after the first one ends.

// File: rtl/ems_pkg.sv
package ems_pkg;

    typedef enum logic [2:0] {
        PH_IDLE = 3'd0,
        PH_ASET = 3'd1,
        PH_AHLD = 3'd2,
        PH_DSET = 3'd3,
        PH_TURN = 3'd4
    } phase_e;

    localparam int ASET_W = 4;
    localparam int AHLD_W = 4;
    localparam int DSET_W = 8;
    localparam int TURN_W = 4;

endpackage

// File: rtl/ems_phase_fsm.sv
module ems_phase_fsm
    import ems_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic              start_write,
    input  logic              start_muxed,
    input  logic [ASET_W-1:0] aset_in,
    input  logic [AHLD_W-1:0] ahld_in,
    input  logic [DSET_W-1:0] dset_in,
    input  logic [TURN_W-1:0] turn_in,
    output phase_e            phase,
    output logic              is_write,
    output logic              is_muxed,
    output logic              last_dset,
    output logic              done
);

    localparam int CW = DSET_W;

    typedef struct packed {
        phase_e            ph;
        logic [CW-1:0]     cnt;
        logic              wr;
        logic              mux;
        logic [AHLD_W-1:0] hld;
        logic [DSET_W-1:0] dset;
        logic [TURN_W-1:0] turn;
        logic              done;
    } fsm_t;

    fsm_t s_q, s_d;

    function automatic logic [CW-1:0] load_cnt(
        input phase_e            p,
        input logic [ASET_W-1:0] a,
        input logic [AHLD_W-1:0] h,
        input logic [DSET_W-1:0] d,
        input logic [TURN_W-1:0] t
    );
        logic [CW-1:0] r;
        r = '0;
        case (p)
            PH_ASET: r = CW'(a) - CW'(1);
            PH_AHLD: r = (h == '0) ? '0 : CW'(h) - CW'(1);
            PH_DSET: r = CW'(d);
            PH_TURN: r = CW'(t) - CW'(1);
            default: r = '0;
        endcase
        return r;
    endfunction

    phase_e nph;
    logic   moving;

    always_comb begin
        s_d      = s_q;
        s_d.done = 1'b0;
        nph      = s_q.ph;
        moving   = 1'b0;
        case (s_q.ph)
            PH_IDLE: begin
                if (start) begin
                    moving = 1'b1;
                    if (aset_in != '0)     nph = PH_ASET;
                    else if (start_muxed)  nph = PH_AHLD;
                    else                   nph = PH_DSET;
                end
            end
            PH_ASET: begin
                if (s_q.cnt == '0) begin
                    moving = 1'b1;
                    nph    = s_q.mux ? PH_AHLD : PH_DSET;
                end
            end
            PH_AHLD: begin
                if (s_q.cnt == '0) begin
                    moving = 1'b1;
                    nph    = PH_DSET;
                end
            end
            PH_DSET: begin
                if (s_q.cnt == '0) begin
                    moving   = 1'b1;
                    s_d.done = 1'b1;
                    nph      = (s_q.turn != '0) ? PH_TURN : PH_IDLE;
                end
            end
            PH_TURN: begin
                if (s_q.cnt == '0) begin
                    moving = 1'b1;
                    nph    = PH_IDLE;
                end
            end
            default: begin
                moving = 1'b1;
                nph    = PH_IDLE;
            end
        endcase

        if (moving) begin
            s_d.ph = nph;
            if (s_q.ph == PH_IDLE) begin
                s_d.wr   = start_write;
                s_d.mux  = start_muxed;
                s_d.hld  = ahld_in;
                s_d.dset = dset_in;
                s_d.turn = turn_in;
                s_d.cnt  = load_cnt(nph, aset_in, ahld_in, dset_in, turn_in);
            end else begin
                s_d.cnt  = load_cnt(nph, aset_in, s_q.hld, s_q.dset, s_q.turn);
            end
        end else if (s_q.ph != PH_IDLE) begin
            s_d.cnt = s_q.cnt - CW'(1);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q <= '{ph: PH_IDLE, default: '0};
        end else begin
            s_q <= s_d;
        end
    end

    assign phase     = s_q.ph;
    assign is_write  = s_q.wr;
    assign is_muxed  = s_q.mux;
    assign last_dset = (s_q.ph == PH_DSET) && (s_q.cnt == '0);
    assign done      = s_q.done;

    // R1
    accept_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (start && s_q.ph == PH_IDLE) |=> (s_q.ph != PH_IDLE));

    // R2
    turn_after_data_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (s_q.ph == PH_TURN) |-> ($past(s_q.ph) == PH_DSET || $past(s_q.ph) == PH_TURN));

    // R3
    hold_only_muxed_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (s_q.ph == PH_AHLD) |-> s_q.mux);

    // R8
    done_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        s_q.done |=> !s_q.done);

endmodule

// File: rtl/ems_pin_drive.sv
module ems_pin_drive
    import ems_pkg::*;
#(
    parameter int AW = 16,
    parameter int DW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          accept,
    input  logic [AW-1:0] req_addr,
    input  logic [DW-1:0] req_wdata,
    input  phase_e        phase,
    input  logic          is_write,
    input  logic          is_muxed,
    input  logic          last_dset,
    input  logic [DW-1:0] ad_in,
    output logic [AW-1:0] addr,
    output logic [DW-1:0] ad_out,
    output logic          ad_oe,
    output logic [DW-1:0] rdata,
    output logic          cs_n,
    output logic          oe_n,
    output logic          we_n,
    output logic          adv_n
);

    typedef struct packed {
        logic [AW-1:0] addr;
        logic [DW-1:0] wdata;
        logic [DW-1:0] rdata;
    } pin_t;

    pin_t p_q, p_d;

    always_comb begin
        p_d = p_q;
        if (accept) begin
            p_d.addr  = req_addr;
            p_d.wdata = req_wdata;
        end
        if (last_dset && !is_write) begin
            p_d.rdata = ad_in;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            p_q <= '0;
        end else begin
            p_q <= p_d;
        end
    end

    logic in_addr_ph;
    logic in_data_ph;

    always_comb begin
        in_addr_ph = (phase == PH_ASET) || (phase == PH_AHLD);
        in_data_ph = (phase == PH_DSET);
        cs_n   = !(in_addr_ph || in_data_ph);
        adv_n  = !(phase == PH_ASET);
        oe_n   = !(in_data_ph && !is_write);
        we_n   = !(in_data_ph && is_write);
        ad_oe  = (in_addr_ph && is_muxed) || (in_data_ph && is_write);
        ad_out = '0;
        if (in_addr_ph && is_muxed) ad_out = DW'(p_q.addr);
        else if (in_data_ph && is_write) ad_out = p_q.wdata;
    end

    assign addr  = p_q.addr;
    assign rdata = p_q.rdata;

    // R5
    oe_we_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(!oe_n && !we_n));

    // R4
    strobe_in_cs_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!oe_n || !we_n || !adv_n) |-> !cs_n);

    // R7
    read_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !oe_n |-> !ad_oe);

endmodule

// File: rtl/ext_mem_seq.sv
module ext_mem_seq
    import ems_pkg::*;
#(
    parameter int AW = 16,
    parameter int DW = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic              req_write,
    input  logic              req_muxed,
    input  logic [AW-1:0]     req_addr,
    input  logic [DW-1:0]     req_wdata,
    input  logic [ASET_W-1:0] cfg_aset,
    input  logic [AHLD_W-1:0] cfg_ahld,
    input  logic [DSET_W-1:0] cfg_dset,
    input  logic [TURN_W-1:0] cfg_turn,
    output logic              busy,
    output logic              done,
    output logic [DW-1:0]     rdata,
    output logic [AW-1:0]     mem_addr,
    output logic [DW-1:0]     mem_ad_out,
    output logic              mem_ad_oe,
    input  logic [DW-1:0]     mem_ad_in,
    output logic              mem_cs_n,
    output logic              mem_oe_n,
    output logic              mem_we_n,
    output logic              mem_adv_n
);

    phase_e phase;
    logic   is_write, is_muxed, last_dset;
    logic   accept;

    assign accept = req_valid && (phase == PH_IDLE);
    assign busy   = (phase != PH_IDLE);

    ems_phase_fsm u_fsm (
        .clk         (clk),
        .rst_n       (rst_n),
        .start       (accept),
        .start_write (req_write),
        .start_muxed (req_muxed),
        .aset_in     (cfg_aset),
        .ahld_in     (cfg_ahld),
        .dset_in     (cfg_dset),
        .turn_in     (cfg_turn),
        .phase       (phase),
        .is_write    (is_write),
        .is_muxed    (is_muxed),
        .last_dset   (last_dset),
        .done        (done)
    );

    ems_pin_drive #(.AW(AW), .DW(DW)) u_pins (
        .clk       (clk),
        .rst_n     (rst_n),
        .accept    (accept),
        .req_addr  (req_addr),
        .req_wdata (req_wdata),
        .phase     (phase),
        .is_write  (is_write),
        .is_muxed  (is_muxed),
        .last_dset (last_dset),
        .ad_in     (mem_ad_in),
        .addr      (mem_addr),
        .ad_out    (mem_ad_out),
        .ad_oe     (mem_ad_oe),
        .rdata     (rdata),
        .cs_n      (mem_cs_n),
        .oe_n      (mem_oe_n),
        .we_n      (mem_we_n),
        .adv_n     (mem_adv_n)
    );

    // R6
    adv_only_setup_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !mem_adv_n |-> (busy && mem_oe_n && mem_we_n));

endmodule

// File: tb/ext_mem_seq_tb.sv
module ext_mem_seq_tb;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0, req_write = 1'b0, req_muxed = 1'b0;
    logic [15:0] req_addr = '0, req_wdata = '0, mem_ad_in = '0;
    logic [3:0]  cfg_aset = '0, cfg_ahld = '0, cfg_turn = '0;
    logic [7:0]  cfg_dset = '0;
    logic        busy, done, mem_ad_oe, mem_cs_n, mem_oe_n, mem_we_n, mem_adv_n;
    logic [15:0] rdata, mem_addr, mem_ad_out;

    int errors = 0;
    int checks = 0;

    always #10 clk = ~clk;

    ext_mem_seq u_dut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
        .req_muxed(req_muxed), .req_addr(req_addr), .req_wdata(req_wdata),
        .cfg_aset(cfg_aset), .cfg_ahld(cfg_ahld), .cfg_dset(cfg_dset), .cfg_turn(cfg_turn),
        .busy(busy), .done(done), .rdata(rdata), .mem_addr(mem_addr),
        .mem_ad_out(mem_ad_out), .mem_ad_oe(mem_ad_oe), .mem_ad_in(mem_ad_in),
        .mem_cs_n(mem_cs_n), .mem_oe_n(mem_oe_n), .mem_we_n(mem_we_n), .mem_adv_n(mem_adv_n)
    );

    // {wr, mux, aset, ahld, dset, turn, addr, wdata, read-in}
    localparam int VW = 70;
    localparam logic [VW-1:0] VECS [0:7] = '{
        {1'b0, 1'b0, 4'd2,  4'd0,  8'd3,   4'd1,  16'h1234, 16'h0000, 16'hBEEF},
        {1'b1, 1'b0, 4'd0,  4'd0,  8'd0,   4'd0,  16'h00F0, 16'hA5A5, 16'h0000},
        {1'b0, 1'b1, 4'd1,  4'd2,  8'd2,   4'd2,  16'h4321, 16'h0000, 16'h1357},
        {1'b1, 1'b1, 4'd3,  4'd0,  8'd1,   4'd0,  16'h8001, 16'h5A5A, 16'h0000},
        {1'b0, 1'b1, 4'd0,  4'd1,  8'd0,   4'd15, 16'h0F0F, 16'h0000, 16'h2468},
        {1'b1, 1'b0, 4'd15, 4'd0,  8'd255, 4'd3,  16'hFFFF, 16'hC3C3, 16'h0000},
        {1'b0, 1'b0, 4'd0,  4'd0,  8'd0,   4'd0,  16'h7777, 16'h0000, 16'h9ABC},
        {1'b1, 1'b1, 4'd15, 4'd15, 8'd4,   4'd15, 16'hABCD, 16'h1111, 16'h0000}
    };

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
        end
    endtask

    task automatic run_access(input logic wr, input logic mux, input logic [3:0] as,
                              input logic [3:0] hl, input logic [7:0] ds, input logic [3:0] tu,
                              input logic [15:0] ad, input logic [15:0] wd, input logic [15:0] ri);
        int e1, e2, e3, len;
        @(negedge clk);
        req_valid = 1'b1; req_write = wr; req_muxed = mux; req_addr = ad; req_wdata = wd;
        cfg_aset = as; cfg_ahld = hl; cfg_dset = ds; cfg_turn = tu; mem_ad_in = ri;
        @(negedge clk);
        req_valid = 1'b0;
        e1  = int'(as);
        e2  = e1 + (mux ? ((hl == 4'd0) ? 1 : int'(hl)) : 0);
        e3  = e2 + int'(ds) + 1;
        len = e3 + int'(tu);
        for (int t = 0; t <= len; t++) begin
            logic in_d, ex_cs_n, ex_adv_n, ex_oe_n, ex_we_n, ex_oe, ex_busy, ex_done;
            in_d     = (t >= e2) && (t < e3);
            ex_cs_n  = !(t < e3);
            ex_adv_n = !(t < e1);
            ex_oe_n  = !(in_d && !wr);
            ex_we_n  = !(in_d && wr);
            ex_oe    = (mux && t < e2) || (in_d && wr);
            ex_busy  = (t < len);
            ex_done  = (t == e3);
            // R2 R3 R4 R5 R6 R1 R8: per-cycle strobe pattern
            check("R2 R3 R4 R5 R6 strobes", {28'd0, mem_cs_n, mem_adv_n, mem_oe_n, mem_we_n},
                  {28'd0, ex_cs_n, ex_adv_n, ex_oe_n, ex_we_n});
            check("R1 busy", {31'd0, busy}, {31'd0, ex_busy});
            check("R8 done", {31'd0, done}, {31'd0, ex_done});
            check("R7 ad_oe", {31'd0, mem_ad_oe}, {31'd0, ex_oe});
            if (ex_oe) check("R7 ad_out", {16'd0, mem_ad_out}, {16'd0, (t < e2) ? ad : wd});
            if (t < e3) check("R7 addr", {16'd0, mem_addr}, {16'd0, ad});
            if (t == len && !wr) check("R8 rdata", {16'd0, rdata}, {16'd0, ri});
            if (t < len) @(negedge clk);
        end
    endtask

    initial begin
        #5_000_000;
        errors++;
        checks++;
        $display("FAIL watchdog expired actual=running expected=finished");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        // R9 reset state
        #25;
        check("R9 reset strobes", {26'd0, busy, done, mem_cs_n, mem_oe_n, mem_we_n, mem_adv_n},
              {26'd0, 1'b0, 1'b0, 1'b1, 1'b1, 1'b1, 1'b1});
        check("R9 reset ad_oe", {31'd0, mem_ad_oe}, 32'd0);
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check("R9 after release", {30'd0, busy, mem_cs_n}, {30'd0, 1'b0, 1'b1});

        for (int i = 0; i < 8; i++) begin
            logic [VW-1:0] v;
            v = VECS[i];
            run_access(v[69], v[68], v[67:64], v[63:60], v[59:52], v[51:48],
                       v[47:32], v[31:16], v[15:0]);
        end

        // R1: request raised during data setup is ignored
        @(negedge clk);
        req_valid = 1'b1; req_write = 1'b1; req_muxed = 1'b0; req_addr = 16'h0101;
        req_wdata = 16'h0202; cfg_aset = 4'd1; cfg_dset = 8'd4; cfg_turn = 4'd1;
        @(negedge clk);
        req_valid = 1'b0;            // t=0 address setup
        @(negedge clk);              // t=1 data setup
        req_valid = 1'b1; req_write = 1'b0; req_addr = 16'h0909;
        @(negedge clk);
        req_valid = 1'b0;
        for (int k = 0; k < 5; k++) @(negedge clk);   // reach t=7 idle
        check("R1 ignored busy", {31'd0, busy}, 32'd0);
        @(negedge clk);
        check("R1 ignored stays idle", {30'd0, busy, mem_oe_n}, {30'd0, 1'b0, 1'b1});
        check("R1 ignored addr", {16'd0, mem_addr}, {16'd0, 16'h0101});

        // R8 R1: done and next acceptance in the same cycle (turnaround zero)
        @(negedge clk);
        req_valid = 1'b1; req_write = 1'b0; req_muxed = 1'b0; req_addr = 16'h3030;
        cfg_aset = 4'd2; cfg_dset = 8'd1; cfg_turn = 4'd0; mem_ad_in = 16'h6060;
        @(negedge clk);              // t=0
        req_addr = 16'h4040;
        for (int k = 0; k < 4; k++) @(negedge clk);   // t=4
        check("R8 overlap done", {30'd0, done, busy}, {30'd0, 1'b1, 1'b0});
        check("R8 overlap rdata", {16'd0, rdata}, {16'd0, 16'h6060});
        @(negedge clk);
        req_valid = 1'b0;
        check("R1 overlap accept", {29'd0, busy, mem_cs_n, mem_adv_n}, {29'd0, 1'b1, 1'b0, 1'b0});
        check("R7 overlap addr", {16'd0, mem_addr}, {16'd0, 16'h4040});
        for (int k = 0; k < 6; k++) @(negedge clk);
        check("R1 overlap end", {31'd0, busy}, 32'd0);

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule